// File: doc/BRIEF.md
# Frequency-Adaptive Positive/Negative Sequence Separator

This block splits a sampled three-phase voltage, given as a stationary-frame pair (alpha, beta), into its positive-sequence and negative-sequence vectors. Each axis feeds its own resonant filter stage. The stage returns a band-passed copy of the input that is in phase with it, and a copy that lags by a quarter period. A small cross-axis network then adds and subtracts these four signals, halved, to form the two sequence vectors. A synchronizing loop downstream would normally use only the positive-sequence pair.

The resonance of both stages is set each sample by an angular-step input (omega times the sample period), so the filters follow the grid when its frequency drifts. The damping factor is a build-time constant and defaults to 0.7071. A lower damping factor rejects harmonics better but settles more slowly. Each filter updates once per valid input sample. All results are registered and appear one clock after the sample.

Top module: `sogi_seq_extractor`

## Requirements
- R1: While rst_n is low, out_valid is 0 and all four sequence outputs read 0. The filter states are cleared, so the first sample after reset is processed from all-zero state.
- R2: Per valid sample and per axis, with input v, in-phase state p and quadrature state q (signed 32-bit, input units scaled by 2^16), gain K = K_GAIN/2^14 and step w = omega_ts/2^16 (omega_ts unsigned): e = v·2^16 − p, p_new = sat(p + floor(w·(floor(K·e) − q))), q_new = sat(q + floor(w·p_new)). Every floor is an arithmetic right shift.
- R3: Each state update saturates to the signed 32-bit range [−2^31, 2^31−1] instead of wrapping.
- R4: Outputs use the new states, with a = alpha axis and b = beta axis, and are then shifted right arithmetically by 17 and clamped to 16-bit signed. pos_alpha = p_a − q_b, pos_beta = q_a + p_b, neg_alpha = p_a + q_b, neg_beta = p_b − q_a.
- R5: out_valid is high exactly in the clock cycle after each cycle with in_valid high, and low otherwise.
- R6: A cycle without in_valid changes neither the filter states nor the outputs, whatever the data inputs do.
- R7: With a balanced positive-sequence input (alpha = A·cos, beta = A·sin) at the frequency given by omega_ts, after settling the positive outputs follow the input within 6 % of A, and both negative outputs stay within 6 % of A.
- R8: With a pure negative-sequence input (alpha = A·cos, beta = −A·sin), after settling the positive outputs stay within 6 % of A, neg_alpha follows A·cos and neg_beta follows −A·sin, each within 6 % of A.
- R9: When omega_ts is changed to match a shifted grid frequency (47 Hz in place of 50 Hz), R7 still holds at the new frequency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe for in_alpha/in_beta |
| in_alpha | input | 16 | Alpha-axis sample, signed |
| in_beta | input | 16 | Beta-axis sample, signed |
| omega_ts | input | 16 | Angular step per sample, unsigned, 16 fraction bits |
| out_valid | output | 1 | Outputs updated this cycle |
| pos_alpha | output | 16 | Positive-sequence alpha, signed |
| pos_beta | output | 16 | Positive-sequence beta, signed |
| neg_alpha | output | 16 | Negative-sequence alpha, signed |
| neg_beta | output | 16 | Negative-sequence beta, signed |

## Verification
The bench compares the outputs bit for bit against the update law over a short burst. A design that used the old in-phase state in the quadrature update, or that swapped a sign in the cross-axis network, fails on the first samples. A burst at full scale with the step input at its maximum drives the states into their limits; a wrapping accumulator would flip sign and diverge from the expected values. Idle gaps with changing data catch state that updates without a strobe. Rotating inputs in both directions and at a retuned frequency catch a network that leaks one sequence into the other, and a centre frequency that does not follow omega_ts.

// File: rtl/sogi_pkg.sv
package sogi_pkg;
  // Integrator state width, fixed for the whole block
  localparam int unsigned SOGI_ACC_W = 32;

  typedef enum logic [0:0] {AX_ALPHA = 1'b0, AX_BETA = 1'b1} sogi_axis_e;

  // One filter's state: in-phase and quadrature integrators
  typedef struct packed {
    logic signed [SOGI_ACC_W-1:0] inph;
    logic signed [SOGI_ACC_W-1:0] quad;
  } sogi_pair_t;
endpackage

// File: rtl/sogi_axis_filter.sv
module sogi_axis_filter
  import sogi_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned WT_W   = 16,
  parameter int unsigned K_W    = 16,
  parameter int unsigned K_GAIN = 11585,
  parameter int unsigned K_FRAC = 14
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     step_en,
  input  logic signed [DATA_W-1:0] sample,
  input  logic        [WT_W-1:0]   wt,
  output sogi_pair_t               nxt
);
  localparam int unsigned ACC_W    = SOGI_ACC_W;
  localparam int unsigned FRAC_EXT = ACC_W - DATA_W;
  localparam int unsigned ERR_W    = ACC_W + 2;
  localparam int unsigned KP_W     = ERR_W + K_W + 1;
  localparam int unsigned T_W      = KP_W + 1;
  localparam int unsigned D1_W     = T_W + WT_W + 1;
  localparam int unsigned D2_W     = ACC_W + WT_W + 1;
  localparam int unsigned S_W      = D1_W + 1;
  localparam logic signed [S_W-1:0] ACC_HI = S_W'({1'b0, {(ACC_W-1){1'b1}}});
  localparam logic signed [S_W-1:0] ACC_LO = ~ACC_HI;
  localparam logic [K_W-1:0] K_V = K_W'(K_GAIN);

  function automatic logic signed [ACC_W-1:0] clamp_acc(input logic signed [S_W-1:0] v);
    if (v > ACC_HI)      clamp_acc = ACC_HI[ACC_W-1:0];
    else if (v < ACC_LO) clamp_acc = ACC_LO[ACC_W-1:0];
    else                 clamp_acc = v[ACC_W-1:0];
  endfunction

  sogi_pair_t state_q, state_d;

  logic signed [ERR_W-1:0] err;
  logic signed [KP_W-1:0]  kprod, kerr;
  logic signed [T_W-1:0]   drive;
  logic signed [D1_W-1:0]  d1prod, d1;
  logic signed [D2_W-1:0]  d2prod, d2;
  logic signed [S_W-1:0]   sum1, sum2;
  logic signed [ACC_W-1:0] inph_n, quad_n;

  // Semi-implicit Euler step: in-phase first, quadrature from the new in-phase
  always_comb begin
    err    = (ERR_W'(sample) <<< FRAC_EXT) - ERR_W'(state_q.inph);
    kprod  = KP_W'(err) * KP_W'($signed({1'b0, K_V}));
    kerr   = kprod >>> K_FRAC;
    drive  = T_W'(kerr) - T_W'(state_q.quad);
    d1prod = D1_W'(drive) * D1_W'($signed({1'b0, wt}));
    d1     = d1prod >>> WT_W;
    sum1   = S_W'(d1) + S_W'(state_q.inph);
    inph_n = clamp_acc(sum1);
    d2prod = D2_W'(inph_n) * D2_W'($signed({1'b0, wt}));
    d2     = d2prod >>> WT_W;
    sum2   = S_W'(d2) + S_W'(state_q.quad);
    quad_n = clamp_acc(sum2);
  end

  always_comb begin
    nxt.inph = inph_n;
    nxt.quad = quad_n;
  end

  always_comb begin
    state_d = state_q;
    if (step_en) state_d = nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/sogi_seq_coupler.sv
module sogi_seq_coupler
  import sogi_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter bit          NEG_EN = 1'b1
) (
  input  sogi_pair_t               ax_a,
  input  sogi_pair_t               ax_b,
  output logic signed [DATA_W-1:0] pos_a,
  output logic signed [DATA_W-1:0] pos_b,
  output logic signed [DATA_W-1:0] neg_a,
  output logic signed [DATA_W-1:0] neg_b
);
  localparam int unsigned ACC_W = SOGI_ACC_W;
  localparam int unsigned SUM_W = ACC_W + 1;
  localparam int unsigned SHIFT = ACC_W - DATA_W + 1;
  localparam logic signed [SUM_W-1:0] OUT_HI = SUM_W'({1'b0, {(DATA_W-1){1'b1}}});
  localparam logic signed [SUM_W-1:0] OUT_LO = ~OUT_HI;

  function automatic logic signed [DATA_W-1:0] scale_out(input logic signed [SUM_W-1:0] s);
    logic signed [SUM_W-1:0] sh;
    sh = s >>> SHIFT;
    if (sh > OUT_HI)      scale_out = OUT_HI[DATA_W-1:0];
    else if (sh < OUT_LO) scale_out = OUT_LO[DATA_W-1:0];
    else                  scale_out = sh[DATA_W-1:0];
  endfunction

  logic signed [SUM_W-1:0] pa_s, pb_s;

  always_comb begin
    pa_s  = SUM_W'(ax_a.inph) - SUM_W'(ax_b.quad);
    pb_s  = SUM_W'(ax_a.quad) + SUM_W'(ax_b.inph);
    pos_a = scale_out(pa_s);
    pos_b = scale_out(pb_s);
  end

  generate
    if (NEG_EN) begin : g_neg
      logic signed [SUM_W-1:0] na_s, nb_s;
      always_comb begin
        na_s  = SUM_W'(ax_a.inph) + SUM_W'(ax_b.quad);
        nb_s  = SUM_W'(ax_b.inph) - SUM_W'(ax_a.quad);
        neg_a = scale_out(na_s);
        neg_b = scale_out(nb_s);
      end
    end else begin : g_no_neg
      assign neg_a = '0;
      assign neg_b = '0;
    end
  endgenerate
endmodule

// File: rtl/sogi_seq_extractor.sv
module sogi_seq_extractor
  import sogi_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned WT_W   = 16,
  parameter int unsigned K_W    = 16,
  parameter int unsigned K_GAIN = 11585,
  parameter int unsigned K_FRAC = 14,
  parameter bit          NEG_EN = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_alpha,
  input  logic signed [DATA_W-1:0] in_beta,
  input  logic        [WT_W-1:0]   omega_ts,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] pos_alpha,
  output logic signed [DATA_W-1:0] pos_beta,
  output logic signed [DATA_W-1:0] neg_alpha,
  output logic signed [DATA_W-1:0] neg_beta
);
  localparam int unsigned N_AX = 2;

  logic signed [DATA_W-1:0] smp [N_AX];
  sogi_pair_t               nxt [N_AX];

  assign smp[AX_ALPHA] = in_alpha;
  assign smp[AX_BETA]  = in_beta;

  generate
    for (genvar ax = 0; ax < N_AX; ax++) begin : g_axis
      sogi_axis_filter #(
        .DATA_W(DATA_W), .WT_W(WT_W), .K_W(K_W),
        .K_GAIN(K_GAIN), .K_FRAC(K_FRAC)
      ) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_en(in_valid),
        .sample (smp[ax]),
        .wt     (omega_ts),
        .nxt    (nxt[ax])
      );
    end
  endgenerate

  logic signed [DATA_W-1:0] cp_pa, cp_pb, cp_na, cp_nb;

  sogi_seq_coupler #(.DATA_W(DATA_W), .NEG_EN(NEG_EN)) u_couple (
    .ax_a (nxt[AX_ALPHA]),
    .ax_b (nxt[AX_BETA]),
    .pos_a(cp_pa),
    .pos_b(cp_pb),
    .neg_a(cp_na),
    .neg_b(cp_nb)
  );

  logic                     vld_d;
  logic signed [DATA_W-1:0] pa_d, pb_d, na_d, nb_d;

  always_comb begin
    vld_d = in_valid;
    pa_d  = pos_alpha;
    pb_d  = pos_beta;
    na_d  = neg_alpha;
    nb_d  = neg_beta;
    if (in_valid) begin
      pa_d = cp_pa;
      pb_d = cp_pb;
      na_d = cp_na;
      nb_d = cp_nb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      pos_alpha <= '0;
      pos_beta  <= '0;
      neg_alpha <= '0;
      neg_beta  <= '0;
    end else begin
      out_valid <= vld_d;
      pos_alpha <= pa_d;
      pos_beta  <= pb_d;
      neg_alpha <= na_d;
      neg_beta  <= nb_d;
    end
  end
endmodule

// File: rtl/sogi_seq_extractor_chk.sv
module sogi_seq_extractor_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic                     out_valid,
  input logic signed [DATA_W-1:0] pos_alpha,
  input logic signed [DATA_W-1:0] pos_beta,
  input logic signed [DATA_W-1:0] neg_alpha,
  input logic signed [DATA_W-1:0] neg_beta
);
  p_valid_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_no_spurious_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_hold_pos_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(pos_alpha) && $stable(pos_beta)));

  p_hold_neg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(neg_alpha) && $stable(neg_beta)));
endmodule

bind sogi_seq_extractor sogi_seq_extractor_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .out_valid(out_valid),
  .pos_alpha(pos_alpha),
  .pos_beta (pos_beta),
  .neg_alpha(neg_alpha),
  .neg_beta (neg_beta)
);

// File: tb/tb_sogi_seq_extractor.sv
module tb_sogi_seq_extractor;
  localparam int    KG   = 11585;
  localparam int    WT50 = 2059;   // 2*pi*50/10000 * 65536
  localparam int    WT47 = 1935;   // 2*pi*47/10000 * 65536
  localparam real   FS   = 10000.0;
  localparam real   PI   = 3.14159265358979;
  localparam int    AMP  = 10000;
  localparam int    TOL  = 600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [15:0] in_alpha = '0, in_beta = '0;
  logic [15:0] omega_ts = '0;
  logic out_valid;
  logic signed [15:0] pos_alpha, pos_beta, neg_alpha, neg_beta;

  always #2 clk = ~clk;

  sogi_seq_extractor dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_alpha(in_alpha), .in_beta(in_beta), .omega_ts(omega_ts),
    .out_valid(out_valid), .pos_alpha(pos_alpha), .pos_beta(pos_beta),
    .neg_alpha(neg_alpha), .neg_beta(neg_beta)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---- independent model of the update law (R2, R3, R4) ----
  logic signed [31:0] m_p [2];
  logic signed [31:0] m_q [2];

  function automatic logic signed [31:0] m_sat32(input logic signed [127:0] v);
    if (v > 128'sd2147483647)       return 32'sh7fffffff;
    else if (v < -128'sd2147483648) return 32'sh80000000;
    else                            return v[31:0];
  endfunction

  function automatic longint m_out(input logic signed [127:0] s);
    logic signed [127:0] sh;
    sh = s >>> 17;
    if (sh > 128'sd32767)       return 32767;
    else if (sh < -128'sd32768) return -32768;
    else                        return longint'(sh);
  endfunction

  task automatic m_clear();
    for (int i = 0; i < 2; i++) begin m_p[i] = '0; m_q[i] = '0; end
  endtask

  task automatic m_axis(input int idx, input longint v, input longint w);
    logic signed [127:0] vv, p, q, e, ke, t, d1, d2, ww;
    logic signed [31:0] pn, qn;
    vv = v; ww = w; p = m_p[idx]; q = m_q[idx];
    e  = vv * 65536 - p;
    ke = (e * KG) >>> 14;
    t  = ke - q;
    d1 = (t * ww) >>> 16;
    pn = m_sat32(p + d1);
    p  = pn;
    d2 = (p * ww) >>> 16;
    qn = m_sat32(q + d2);
    m_p[idx] = pn; m_q[idx] = qn;
  endtask

  // Captured outputs, one clock after the strobe
  logic signed [15:0] c_pa, c_pb, c_na, c_nb;
  logic c_v;

  task automatic send(input int va, input int vb, input int w);
    @(negedge clk);
    in_alpha = 16'(va); in_beta = 16'(vb); omega_ts = 16'(w); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    c_v = out_valid; c_pa = pos_alpha; c_pb = pos_beta; c_na = neg_alpha; c_nb = neg_beta;
  endtask

  task automatic send_cmp(input int va, input int vb, input int w, input string req, input int idx);
    logic signed [127:0] pa, pb, qa, qb;
    longint e_pa, e_pb, e_na, e_nb;
    send(va, vb, w);
    m_axis(0, va, w); m_axis(1, vb, w);
    pa = m_p[0]; qa = m_q[0]; pb = m_p[1]; qb = m_q[1];
    e_pa = m_out(pa - qb); e_pb = m_out(qa + pb);
    e_na = m_out(pa + qb); e_nb = m_out(pb - qa);
    chk(c_pa == e_pa, req, $sformatf("pos_alpha sample %0d", idx), c_pa, e_pa);
    chk(c_pb == e_pb, req, $sformatf("pos_beta sample %0d", idx), c_pb, e_pb);
    chk(c_na == e_na, req, $sformatf("neg_alpha sample %0d", idx), c_na, e_na);
    chk(c_nb == e_nb, req, $sformatf("neg_beta sample %0d", idx), c_nb, e_nb);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; in_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    chk(pos_alpha == 0 && pos_beta == 0, "R1", "pos outputs in reset", pos_alpha, 0);
    chk(neg_alpha == 0 && neg_beta == 0, "R1", "neg outputs in reset", neg_alpha, 0);
    rst_n = 1'b1;
    m_clear();
  endtask

  // R2 / R4 / R5: exact burst from cleared state
  task automatic t_exact();
    int va [8] = '{12000, -8000, 30000, 0, -32768, 5000, 20000, -15000};
    int vb [8] = '{0, 7000, -20000, 32767, 100, -9000, 1, 25000};
    do_reset();
    for (int i = 0; i < 8; i++) begin
      send_cmp(va[i], vb[i], WT50 + i * 300, "R2", i);
      chk(c_v == 1'b1, "R5", "out_valid after strobe", c_v, 1);
    end
    @(negedge clk);
    chk(out_valid == 1'b0, "R5", "out_valid with no strobe", out_valid, 0);
  endtask

  // R6: idle cycles with changing data must not move state or outputs
  task automatic t_hold();
    logic signed [15:0] h_pa, h_pb, h_na, h_nb;
    h_pa = c_pa; h_pb = c_pb; h_na = c_na; h_nb = c_nb;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      in_alpha = 16'(i * 5000 - 12000); in_beta = 16'(7000 - i * 3000);
      omega_ts = 16'(i * 9000);
    end
    @(negedge clk);
    chk(pos_alpha == h_pa && pos_beta == h_pb, "R6", "pos held while idle", pos_alpha, h_pa);
    chk(neg_alpha == h_na && neg_beta == h_nb, "R6", "neg held while idle", neg_alpha, h_na);
    send_cmp(-4000, 9000, WT50, "R6", 100);
  endtask

  // R3: full-scale drive with maximum step forces the states into their limits
  task automatic t_sat();
    do_reset();
    for (int i = 0; i < 30; i++) begin
      send_cmp((i % 4 < 2) ? 32767 : -32768, (i % 3 == 0) ? -32768 : 32767, 65535, "R3", i);
    end
  endtask

  // R7 / R8 / R9: rotating inputs, tolerance check after settling
  task automatic t_wave(input real f, input int w, input bit negseq, input string req);
    int e_max [4];
    real th;
    int xa, xb;
    longint ea, eb, ec, ed;
    do_reset();
    for (int k = 0; k < 4; k++) e_max[k] = 0;
    for (int n = 0; n < 2400; n++) begin
      th = 2.0 * PI * f * real'(n) / FS;
      xa = int'(real'(AMP) * $cos(th));
      xb = negseq ? -int'(real'(AMP) * $sin(th)) : int'(real'(AMP) * $sin(th));
      send(xa, xb, w);
      if (n >= 2000) begin
        if (!negseq) begin
          ea = c_pa - xa; eb = c_pb - xb; ec = c_na; ed = c_nb;
        end else begin
          ea = c_pa; eb = c_pb; ec = c_na - xa; ed = c_nb - xb;
        end
        if (ea < 0) ea = -ea;
        if (eb < 0) eb = -eb;
        if (ec < 0) ec = -ec;
        if (ed < 0) ed = -ed;
        if (ea > e_max[0]) e_max[0] = int'(ea);
        if (eb > e_max[1]) e_max[1] = int'(eb);
        if (ec > e_max[2]) e_max[2] = int'(ec);
        if (ed > e_max[3]) e_max[3] = int'(ed);
      end
    end
    chk(e_max[0] <= TOL, req, "pos_alpha max error", e_max[0], TOL);
    chk(e_max[1] <= TOL, req, "pos_beta max error", e_max[1], TOL);
    chk(e_max[2] <= TOL, req, "neg_alpha max error", e_max[2], TOL);
    chk(e_max[3] <= TOL, req, "neg_beta max error", e_max[3], TOL);
  endtask

  // R1: reset in the middle of operation clears the filter states
  task automatic t_midreset();
    for (int n = 0; n < 50; n++) send(8000, -3000 + n * 100, WT50);
    do_reset();
    send_cmp(15000, -6000, WT50, "R1", 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    m_clear();
    c_pa = '0; c_pb = '0; c_na = '0; c_nb = '0; c_v = 1'b0;
    t_exact();
    t_hold();
    t_sat();
    t_wave(50.0, WT50, 1'b0, "R7");
    t_wave(50.0, WT50, 1'b1, "R8");
    t_wave(47.0, WT47, 1'b0, "R9");
    t_midreset();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule